// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

A purely combinational binary adder that avoids a ripple chain at every level. Each bit position first reduces its operand pair to a generate flag (both bits set) and a propagate flag (bits differ). A pair of zeros absorbs any incoming carry, a pair of ones creates one regardless of the input, and a mixed pair passes the incoming carry through unchanged. Each group of `GRP_W` bits expands the carry equations into sum-of-products form, so all of its internal carries come from its local flags and its carry-in in one flat step. Each group also reports its own generate and propagate.

A second lookahead stage applies the same expansion to the group flags and the external carry-in. It delivers the carry into every group at once, plus the block-wide generate and propagate. Those two block flags are brought out so that a wider adder can stack another level on top. The default build is 16 bits as four groups of four. Each sum bit is the bit's propagate flag XOR the carry into that bit.

Top module: `cla2_adder`

## Requirements
- R1: `sum` equals the low `W` bits of `a + b + cin`, where `W = GRP_W*NUM_GRP` (16 by default).
- R2: `cout` equals bit `W` of the unsigned sum `a + b + cin`.
- R3: `grp_p` is 1 exactly when `a[i] != b[i]` for every bit position i.
- R4: `grp_g` is 1 exactly when `a + b`, taken with no carry-in, is at least `2**W`.
- R5: `cout` equals `grp_g | (grp_p & cin)`. A set `grp_g` forces `cout` to 1, and a set `grp_p` makes `cout` follow `cin`.
- R6: The carry into group k (bits `k*GRP_W` upward) equals the carry out of the addition of the bits below it plus `cin`. Group 0 receives `cin` itself.
- R7: With a full propagate chain (`a ^ b` all ones), `cin = 1` gives `sum = 0` and `cout = 1`, and `cin = 0` gives `sum` all ones and `cout = 0`.
- R8: With both operands zero, the carry is killed: `cin = 1` gives `sum = 1`, `cout = 0`, `grp_g = 0` and `grp_p = 0`.
- R9: Elaboration stops with an error when `GRP_W` or `NUM_GRP` is below 1 or above the fan-in limit of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of the top bit |
| grp_g | output | 1 | Block-wide generate |
| grp_p | output | 1 | Block-wide propagate |

## Verification
The bench builds the default 16-bit arrangement (four groups of four). It drives seeded random operands into it, together with directed patterns: all-ones plus one, alternating propagate chains, carries that must jump several whole groups, and zero operands. A second instance uses two-bit groups in a three-group arrangement, which makes the operand space small enough (6 bits plus carry-in, 8192 cases) to sweep exhaustively. That sweep reaches every combination of group generate, propagate and kill at the second level, including the cases with a single group per level boundary.

// File: rtl/cla_pkg.sv
package cla_pkg;
   // Largest number of product terms an expanded lookahead may fan into.
   localparam int unsigned CLA_MAX_FANIN = 8;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg (
   input  logic x,
   input  logic y,
   output logic gen,
   output logic prop
);
   assign gen  = x & y;
   assign prop = x ^ y;
endmodule

// File: rtl/cla_lookahead.sv
// Flat lookahead over N generate/propagate pairs. Each carry is written
// as an OR of products, with no carry chained through another carry.
module cla_lookahead #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] g,
   input  logic [N-1:0] p,
   input  logic         cin,
   output logic [N-1:0] c,
   output logic         gg,
   output logic         gp
);
   always_comb begin
      for (int k = 0; k < N; k++) begin
         logic acc;
         logic term;
         // term seeded by the outer carry-in, then by each generate below k
         term = cin;
         for (int m = 0; m < k; m++) term = term & p[m];
         acc = term;
         for (int j = 0; j < k; j++) begin
            term = g[j];
            for (int m = j + 1; m < k; m++) term = term & p[m];
            acc = acc | term;
         end
         c[k] = acc;
      end
   end

   always_comb begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < N; j++) begin
         term = g[j];
         for (int m = j + 1; m < N; m++) term = term & p[m];
         acc = acc | term;
      end
      gg = acc;
   end

   assign gp = &p;
endmodule

// File: rtl/cla_group.sv
module cla_group #(
   parameter int unsigned GRP_W = 4
) (
   input  logic [GRP_W-1:0] a,
   input  logic [GRP_W-1:0] b,
   input  logic             cin,
   output logic [GRP_W-1:0] sum,
   output logic             gen,
   output logic             prop
);
   logic [GRP_W-1:0] bit_g;
   logic [GRP_W-1:0] bit_p;
   logic [GRP_W-1:0] bit_c;

   for (genvar i = 0; i < GRP_W; i++) begin : g_bit
      cla_bit_pg u_pg (
         .x    (a[i]),
         .y    (b[i]),
         .gen  (bit_g[i]),
         .prop (bit_p[i])
      );
   end

   cla_lookahead #(.N(GRP_W)) u_la (
      .g   (bit_g),
      .p   (bit_p),
      .cin (cin),
      .c   (bit_c),
      .gg  (gen),
      .gp  (prop)
   );

   assign sum = bit_p ^ bit_c;
endmodule

// File: rtl/cla2_adder.sv
module cla2_adder #(
   parameter int unsigned GRP_W   = 4,
   parameter int unsigned NUM_GRP = 4,
   localparam int unsigned W      = GRP_W * NUM_GRP
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         grp_g,
   output logic         grp_p
);
   import cla_pkg::*;

   // R9: parameter range checked at elaboration
   if (GRP_W < 1 || GRP_W > CLA_MAX_FANIN) begin : g_bad_grp_w
      $error("cla2_adder: GRP_W out of range");
   end
   if (NUM_GRP < 1 || NUM_GRP > CLA_MAX_FANIN) begin : g_bad_num_grp
      $error("cla2_adder: NUM_GRP out of range");
   end

   logic [NUM_GRP-1:0] blk_g;
   logic [NUM_GRP-1:0] blk_p;
   logic [NUM_GRP-1:0] grp_c;

   for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
      cla_group #(.GRP_W(GRP_W)) u_grp (
         .a    (a[k*GRP_W +: GRP_W]),
         .b    (b[k*GRP_W +: GRP_W]),
         .cin  (grp_c[k]),
         .sum  (sum[k*GRP_W +: GRP_W]),
         .gen  (blk_g[k]),
         .prop (blk_p[k])
      );
   end

   if (NUM_GRP > 1) begin : g_level2
      cla_lookahead #(.N(NUM_GRP)) u_l2 (
         .g   (blk_g),
         .p   (blk_p),
         .cin (cin),
         .c   (grp_c),
         .gg  (grp_g),
         .gp  (grp_p)
      );
   end else begin : g_single
      assign grp_c[0] = cin;
      assign grp_g    = blk_g[0];
      assign grp_p    = blk_p[0];
   end

   assign cout = grp_g | (grp_p & cin);
endmodule

// File: rtl/cla2_adder_chk.sv
module cla2_adder_chk #(
   parameter int unsigned GRP_W   = 4,
   parameter int unsigned NUM_GRP = 4,
   localparam int unsigned W      = GRP_W * NUM_GRP
) (
   input logic [W-1:0]       a,
   input logic [W-1:0]       b,
   input logic               cin,
   input logic [W-1:0]       sum,
   input logic               cout,
   input logic               grp_g,
   input logic               grp_p,
   input logic [NUM_GRP-1:0] grp_c
);
   logic [W:0] full;
   logic [W:0] nocarry;
   assign full    = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
   assign nocarry = {1'b0, a} + {1'b0, b};

   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         // R1
         sum_match_chk: assert (sum == full[W-1:0]);
         // R2
         carry_out_chk: assert (cout == full[W]);
         // R3
         block_prop_chk: assert (grp_p == (&(a ^ b)));
         // R4
         block_gen_chk: assert (grp_g == nocarry[W]);
         // R5
         cout_form_chk: assert (cout == (grp_g | (grp_p & cin)));
      end
   end

   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         for (int k = 0; k < NUM_GRP; k++) begin
            logic [W:0] msk;
            logic [W:0] part;
            msk  = ({{W{1'b0}}, 1'b1} << (k * GRP_W)) - 1'b1;
            part = ({1'b0, a} & msk) + ({1'b0, b} & msk) + {{W{1'b0}}, cin};
            // R6
            group_carry_chk: assert (grp_c[k] == part[k * GRP_W]);
         end
      end
   end
endmodule

bind cla2_adder cla2_adder_chk #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_chk (
   .a     (a),
   .b     (b),
   .cin   (cin),
   .sum   (sum),
   .cout  (cout),
   .grp_g (grp_g),
   .grp_p (grp_p),
   .grp_c (grp_c)
);

// File: tb/sim_cla2_adder.sv
`timescale 1ns/1ps
module sim_cla2_adder;
   localparam int W0 = 16;
   localparam int W1 = 6;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [W0-1:0] a0, b0, s0;
   logic          ci0, co0, g0, p0;
   logic [W1-1:0] a1, b1, s1;
   logic          ci1, co1, g1, p1;

   cla2_adder u0 (
      .a(a0), .b(b0), .cin(ci0), .sum(s0), .cout(co0), .grp_g(g0), .grp_p(p0)
   );

   cla2_adder #(.GRP_W(2), .NUM_GRP(3)) u1 (
      .a(a1), .b(b1), .cin(ci1), .sum(s1), .cout(co1), .grp_g(g1), .grp_p(p1)
   );

   function automatic logic [W0:0] exp_add16(logic [W0-1:0] x, logic [W0-1:0] y, logic c);
      return {1'b0, x} + {1'b0, y} + {{W0{1'b0}}, c};
   endfunction

   function automatic logic [W1:0] exp_add6(logic [W1-1:0] x, logic [W1-1:0] y, logic c);
      return {1'b0, x} + {1'b0, y} + {{W1{1'b0}}, c};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
      n_run++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // Drive one vector into u0, let it settle, then compare all outputs.
   task automatic vec16(logic [W0-1:0] x, logic [W0-1:0] y, logic c, string tag);
      logic [W0:0] e, en;
      @(negedge clk);
      a0 = x; b0 = y; ci0 = c;
      #1;
      e  = exp_add16(x, y, c);
      en = exp_add16(x, y, 1'b0);
      chk({tag, " R1 sum"}, 32'(s0), 32'(e[W0-1:0]));
      chk({tag, " R2 cout"}, 32'(co0), 32'(e[W0]));
      chk({tag, " R3 grp_p"}, 32'(p0), 32'(&(x ^ y)));
      chk({tag, " R4 grp_g"}, 32'(g0), 32'(en[W0]));
      chk({tag, " R5 cout form"}, 32'(co0), 32'(en[W0] | ((&(x ^ y)) & c)));
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W0:0] e;
      void'($urandom(32'h1f2e3d4c));
      a0 = '0; b0 = '0; ci0 = 1'b0;
      a1 = '0; b1 = '0; ci1 = 1'b0;
      @(negedge clk); #1;
      // reset-state style check: zero inputs give zero outputs
      chk("R1 idle sum", 32'(s0), 32'd0);
      chk("R2 idle cout", 32'(co0), 32'd0);

      // R7: full propagate chains
      @(negedge clk);
      a0 = 16'hFFFF; b0 = 16'h0000; ci0 = 1'b1; #1;
      chk("R7 ones+cin sum", 32'(s0), 32'd0);
      chk("R7 ones+cin cout", 32'(co0), 32'd1);
      @(negedge clk);
      a0 = 16'hAAAA; b0 = 16'h5555; ci0 = 1'b0; #1;
      chk("R7 chain no cin sum", 32'(s0), 32'hFFFF);
      chk("R7 chain no cin cout", 32'(co0), 32'd0);

      // R8: carry killed by zero operands
      @(negedge clk);
      a0 = '0; b0 = '0; ci0 = 1'b1; #1;
      chk("R8 kill sum", 32'(s0), 32'd1);
      chk("R8 kill cout", 32'(co0), 32'd0);
      chk("R8 kill grp_g", 32'(g0), 32'd0);
      chk("R8 kill grp_p", 32'(p0), 32'd0);

      // R6: carries that must cross whole groups
      vec16(16'hFFFF, 16'h0001, 1'b0, "R6 all-ones+1");
      vec16(16'h0FFF, 16'h0001, 1'b0, "R6 skip3");
      vec16(16'h00F0, 16'h0F10, 1'b0, "R6 gen mid");
      vec16(16'h8000, 16'h8000, 1'b0, "R6 top gen");
      vec16(16'h7FFF, 16'h0000, 1'b1, "R6 ripple via cin");
      vec16(16'hF0F0, 16'h0F0F, 1'b1, "R6 prop chain cin");
      vec16(16'h000F, 16'h0001, 1'b0, "R6 group0 gen");

      // random vectors, seeded above
      for (int i = 0; i < 2000; i++) begin
         vec16(16'($urandom), 16'($urandom), 1'($urandom), "rand");
      end

      // exhaustive sweep of the 6-bit build
      for (int x = 0; x < 64; x++) begin
         for (int y = 0; y < 64; y++) begin
            for (int c = 0; c < 2; c++) begin
               logic [W1:0] e6, e6n;
               @(negedge clk);
               a1 = 6'(x); b1 = 6'(y); ci1 = 1'(c);
               #1;
               e6  = exp_add6(6'(x), 6'(y), 1'(c));
               e6n = exp_add6(6'(x), 6'(y), 1'b0);
               chk("R1 small sum", 32'(s1), 32'(e6[W1-1:0]));
               chk("R2 small cout", 32'(co1), 32'(e6[W1]));
               chk("R3 small grp_p", 32'(p1), 32'(&(6'(x) ^ 6'(y))));
               chk("R4 small grp_g", 32'(g1), 32'(e6n[W1]));
            end
         end
      end

      e = exp_add16(16'h1234, 16'h4321, 1'b1);
      vec16(16'h1234, 16'h4321, 1'b1, "R1 final");
      chk("R1 final direct", 32'(s0), 32'(e[W0-1:0]));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule